// File: doc/BRIEF.md
# Parallel Host Bus Port (8080 / 6800, 8 or 16 bit)

This block is the parallel half of a display controller's host port. A host processor reaches the controller through a chip select, a register-select line, two strobe pins and a 16-bit data bus. A three-bit strap picks the strobe protocol and the bus width. In the 8080-style protocol the two pins are separate active-low write and read strobes. In the 6800-style protocol one pin is a read/write level and the other is an active-high enable.

All bus pins are asynchronous to the system clock. They are passed through a two-stage synchroniser, and edges are detected in the clock domain. Each completed write produces a one-clock event with its data and a command/data tag. Each read produces a one-clock request. The read value returned on `rd_data` in that cycle is then presented on `bus_out`, with two output-enable signals that model the tri-state drivers of the lower and upper bus halves.

Top module: `hostbus_par_if`

## Requirements
- R1: `mode_strap[2:0]` is read as {bit2,bit1,bit0}. 3'b111 selects 8080 16-bit, 3'b110 selects 8080 8-bit, 3'b100 selects 6800 16-bit and 3'b011 selects 6800 8-bit. Any other code produces no `wr_valid`, no `rd_req` and never drives the bus.
- R2: While `cs_n` is high, strobe activity produces no write event, no read request and no bus drive.
- R3: `rs` high tags an access as display data and `rs` low tags it as command: `wr_is_data` (or `rd_is_data`) equals `rs` at the time of the access.
- R4: In 8080 modes a rising edge of `wr_rw` (the write strobe), with `cs_n` low, gives `wr_valid` high for exactly one clock on the third rising clock edge after the strobe edge, with `wr_data` equal to the bus value.
- R5: In 6800 modes a falling edge of `rd_en` (the enable) while `wr_rw` is low is a write, timed as in R4. A falling edge while `wr_rw` is high produces no write.
- R6: In 8-bit modes `wr_data[15:8]` is zero and `wr_data[7:0]` equals `bus_in[7:0]`.
- R7: In 8080 modes `rd_en` (the read strobe) going low with `cs_n` low gives one `rd_req` pulse on the third clock edge after the edge. The `rd_data` value of that cycle appears on `bus_out` with `bus_oe_lo` high from the next edge until the read ends.
- R8: In 6800 modes `rd_en` going high while `wr_rw` is high is a read, timed as in R7.
- R9: `bus_oe_hi` is asserted only in 16-bit modes, together with `bus_oe_lo`. In 8-bit modes `bus_out[15:8]` is zero.
- R10: When the read strobe (or the enable) returns to inactive, `bus_oe_lo` and `bus_oe_hi` are low by the third clock edge after that.
- R11: While `rst_n` is low, `wr_valid`, `rd_req`, `bus_oe_lo` and `bus_oe_hi` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_strap | input | 3 | Protocol and width strap |
| cs_n | input | 1 | Active-low chip select |
| rs | input | 1 | Register select: 1 data, 0 command |
| wr_rw | input | 1 | 8080 write strobe (low active) / 6800 read-write level |
| rd_en | input | 1 | 8080 read strobe (low active) / 6800 enable |
| bus_in | input | 16 | Data bus as seen from the pins |
| bus_out | output | 16 | Read data driven toward the pins |
| bus_oe_lo | output | 1 | Drive enable for bits 7:0 |
| bus_oe_hi | output | 1 | Drive enable for bits 15:8 |
| wr_valid | output | 1 | One-clock write event |
| wr_is_data | output | 1 | Tag of the write event |
| wr_data | output | 16 | Write payload |
| rd_req | output | 1 | One-clock read request |
| rd_is_data | output | 1 | Tag of the read request |
| rd_data | input | 16 | Read value, sampled while rd_req is high |

## Verification
Writes are applied in all four valid modes with different values and both `rs` levels. The 16-bit and 8-bit cases separate correct upper-half masking from leakage. The 8080 and 6800 cases separate the rising-edge write rule from the falling-edge write rule. A 6800 enable pulse with the read level high separates a read from a write on the same edge. Strobe pulses with chip select high, and pulses under an unlisted strap code, must leave every output quiet. Reads check the exact request cycle, the driven value, upper-half gating and release after the strobe ends.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

  typedef struct packed {
    logic ok;    // strap code is one of the four supported ones
    logic m68;   // level-plus-enable protocol
    logic wide;  // 16-bit bus
  } bus_cfg_t;

  function automatic bus_cfg_t strap_to_cfg(input logic [2:0] s);
    bus_cfg_t c;
    case (s)
      3'b111:  c = {1'b1, 1'b0, 1'b1};
      3'b110:  c = {1'b1, 1'b0, 1'b0};
      3'b100:  c = {1'b1, 1'b1, 1'b1};
      3'b011:  c = {1'b1, 1'b1, 1'b0};
      default: c = 3'b000;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hpb_strobe_dec.sv
module hpb_strobe_dec
  import hpb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_cfg_t cfg,
  input  logic     cs_n_s,
  input  logic     a_s,      // write strobe or read/write level
  input  logic     b_s,      // read strobe or enable
  output logic     wr_fire,
  output logic     rd_active
);
  logic cs_n_q, a_q, b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      a_q    <= 1'b1;
      b_q    <= 1'b1;
    end else begin
      cs_n_q <= cs_n_s;
      a_q    <= a_s;
      b_q    <= b_s;
    end
  end

  // chip select must be low on both samples that form an edge
  logic sel_held;
  assign sel_held = !cs_n_s && !cs_n_q;

  always_comb begin
    wr_fire   = 1'b0;
    rd_active = 1'b0;
    if (cfg.ok) begin
      if (cfg.m68) begin
        wr_fire   = sel_held && !a_s && !b_s && b_q;
        rd_active = !cs_n_s && a_s && b_s;
      end else begin
        wr_fire   = sel_held && a_s && !a_q;
        rd_active = !cs_n_s && !b_s;
      end
    end
  end
endmodule

// File: rtl/hpb_wr_path.sv
module hpb_wr_path #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic          fire,
  input  logic          rs_s,
  input  logic [DW-1:0] d_s,
  output logic          wr_valid,
  output logic          wr_is_data,
  output logic [DW-1:0] wr_data
);
  localparam int HALF = DW / 2;

  function automatic logic [DW-1:0] fit_width(input logic [DW-1:0] v, input logic w);
    return w ? v : {{(DW-HALF){1'b0}}, v[HALF-1:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid   <= 1'b0;
      wr_is_data <= 1'b0;
      wr_data    <= '0;
    end else begin
      wr_valid <= fire;
      if (fire) begin
        wr_is_data <= rs_s;
        wr_data    <= fit_width(d_s, wide);
      end
    end
  end
endmodule

// File: rtl/hpb_rd_path.sv
module hpb_rd_path #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic          rd_active,
  input  logic          rs_s,
  input  logic [DW-1:0] rd_data,
  output logic          rd_req,
  output logic          rd_is_data,
  output logic [DW-1:0] bus_out,
  output logic          oe_lo,
  output logic          oe_hi
);
  localparam int HALF = DW / 2;

  function automatic logic [DW-1:0] fit_width(input logic [DW-1:0] v, input logic w);
    return w ? v : {{(DW-HALF){1'b0}}, v[HALF-1:0]};
  endfunction

  logic          act_q;
  logic          start;
  logic [DW-1:0] hold;

  assign start = rd_active && !act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      rd_req     <= 1'b0;
      rd_is_data <= 1'b0;
      hold       <= '0;
      oe_lo      <= 1'b0;
      oe_hi      <= 1'b0;
    end else begin
      act_q  <= rd_active;
      rd_req <= start;
      if (start)  rd_is_data <= rs_s;
      if (rd_req) hold       <= fit_width(rd_data, wide);
      oe_lo <= rd_active && act_q;
      oe_hi <= rd_active && act_q && wide;
    end
  end

  assign bus_out = oe_lo ? hold : '0;
endmodule

// File: rtl/hostbus_par_if.sv
module hostbus_par_if
  import hpb_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_strap,
  input  logic          cs_n,
  input  logic          rs,
  input  logic          wr_rw,
  input  logic          rd_en,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe_lo,
  output logic          bus_oe_hi,
  output logic          wr_valid,
  output logic          wr_is_data,
  output logic [DW-1:0] wr_data,
  output logic          rd_req,
  output logic          rd_is_data,
  input  logic [DW-1:0] rd_data
);
  localparam int SW = DW + 4;
  localparam logic [SW-1:0] IDLE = {1'b1, 1'b1, 1'b1, 1'b0, {DW{1'b0}}};

  bus_cfg_t cfg;
  assign cfg = strap_to_cfg(mode_strap);

  logic [SW-1:0] pins_s;
  logic          cs_n_s, a_s, b_s, rs_s;
  logic [DW-1:0] d_s;

  hpb_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cs_n, wr_rw, rd_en, rs, bus_in}),
    .q    (pins_s)
  );
  assign {cs_n_s, a_s, b_s, rs_s, d_s} = pins_s;

  // named internal events
  logic wr_fire, rd_active;

  hpb_strobe_dec u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .cs_n_s   (cs_n_s),
    .a_s      (a_s),
    .b_s      (b_s),
    .wr_fire  (wr_fire),
    .rd_active(rd_active)
  );

  hpb_wr_path #(.DW(DW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide      (cfg.wide),
    .fire      (wr_fire),
    .rs_s      (rs_s),
    .d_s       (d_s),
    .wr_valid  (wr_valid),
    .wr_is_data(wr_is_data),
    .wr_data   (wr_data)
  );

  hpb_rd_path #(.DW(DW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide      (cfg.wide),
    .rd_active (rd_active),
    .rs_s      (rs_s),
    .rd_data   (rd_data),
    .rd_req    (rd_req),
    .rd_is_data(rd_is_data),
    .bus_out   (bus_out),
    .oe_lo     (bus_oe_lo),
    .oe_hi     (bus_oe_hi)
  );
endmodule

// File: rtl/hpb_checker.sv
module hpb_checker
  import hpb_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode_strap,
  input logic          wr_valid,
  input logic [DW-1:0] wr_data,
  input logic          rd_req,
  input logic          bus_oe_lo,
  input logic          bus_oe_hi
);
  localparam int HALF = DW / 2;
  bus_cfg_t c;
  assign c = strap_to_cfg(mode_strap);

  a_r9_hi_needs_wide: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_hi |-> (c.ok && c.wide));

  a_r9_hi_with_lo: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_hi |-> bus_oe_lo);

  a_r4_single_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  a_r7_single_read_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  a_r7_drive_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_lo) |-> $past(rd_req));

  a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !c.wide) |-> (wr_data[DW-1:HALF] == '0));
endmodule

bind hostbus_par_if hpb_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_strap(mode_strap),
  .wr_valid  (wr_valid),
  .wr_data   (wr_data),
  .rd_req    (rd_req),
  .bus_oe_lo (bus_oe_lo),
  .bus_oe_hi (bus_oe_hi)
);

// File: tb/hostbus_par_if_tb_top.sv
module hostbus_par_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_strap = 3'b111;
  logic        cs_n = 1'b1, rs = 1'b0, wr_rw = 1'b1, rd_en = 1'b1;
  logic [15:0] bus_in = '0, rd_data = '0;
  logic [15:0] bus_out, wr_data;
  logic        bus_oe_lo, bus_oe_hi, wr_valid, wr_is_data, rd_req, rd_is_data;

  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, req_cnt = 0, oe_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hostbus_par_if dut_i (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .cs_n(cs_n), .rs(rs),
    .wr_rw(wr_rw), .rd_en(rd_en), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe_lo(bus_oe_lo), .bus_oe_hi(bus_oe_hi), .wr_valid(wr_valid),
    .wr_is_data(wr_is_data), .wr_data(wr_data), .rd_req(rd_req),
    .rd_is_data(rd_is_data), .rd_data(rd_data)
  );

  always @(negedge clk) begin
    if (wr_valid) wr_cnt++;
    if (rd_req) req_cnt++;
    if (bus_oe_lo || bus_oe_hi) oe_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_idle(input logic [2:0] m);
    @(negedge clk);
    cs_n = 1'b1;
    mode_strap = m;
    wr_rw = (m == 3'b100 || m == 3'b011) ? 1'b1 : 1'b1;
    rd_en = (m == 3'b100 || m == 3'b011) ? 1'b0 : 1'b1;
    clks(5);
    cs_n = 1'b0;
    clks(4);
  endtask

  // watch wr_valid for 6 clocks after a write-ending edge driven at a negedge
  task automatic watch_write(input string tag, input logic [15:0] exp_d, input logic exp_tag);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 3) begin
        chk(wr_valid == 1'b1, {tag, " pulse"}, 32'(wr_valid), 32'd1);
        chk(wr_data == exp_d, {tag, " data"}, 32'(wr_data), 32'(exp_d));
        chk(wr_is_data == exp_tag, "R3 write tag", 32'(wr_is_data), 32'(exp_tag));
      end else if (wr_valid) begin
        chk(1'b0, {tag, " stray pulse"}, 32'(wr_valid), 32'd0);
      end
    end
  endtask

  task automatic t_reset;
    chk({wr_valid, rd_req, bus_oe_lo, bus_oe_hi} == 4'b0, "R11 reset outputs",
        32'({wr_valid, rd_req, bus_oe_lo, bus_oe_hi}), 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_w80(input logic [2:0] m, input logic [15:0] d, input logic tg, input string tag);
    go_idle(m);
    bus_in = d; rs = tg;
    clks(3); wr_rw = 1'b0;
    clks(4); wr_rw = 1'b1;
    watch_write(tag, (m == 3'b111) ? d : {8'h00, d[7:0]}, tg);
  endtask

  task automatic t_w68(input logic [2:0] m, input logic [15:0] d, input logic tg, input string tag);
    go_idle(m);
    bus_in = d; rs = tg; wr_rw = 1'b0;
    clks(3); rd_en = 1'b1;
    clks(4); rd_en = 1'b0;
    watch_write(tag, (m == 3'b100) ? d : {8'h00, d[7:0]}, tg);
    wr_rw = 1'b1;
  endtask

  task automatic t_read(input logic [2:0] m, input logic [15:0] v, input logic tg, input string tag);
    bit is68 = (m == 3'b100 || m == 3'b011);
    bit wide = (m == 3'b111 || m == 3'b100);
    logic [15:0] e = wide ? v : {8'h00, v[7:0]};
    go_idle(m);
    rd_data = v; rs = tg; wr_rw = 1'b1;
    clks(3);
    rd_en = is68 ? 1'b1 : 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 3) begin
        chk(rd_req == 1'b1, {tag, " request"}, 32'(rd_req), 32'd1);
        chk(rd_is_data == tg, "R3 read tag", 32'(rd_is_data), 32'(tg));
      end else if (rd_req) chk(1'b0, {tag, " stray request"}, 32'(rd_req), 32'd0);
      if (i == 5) begin
        chk(bus_oe_lo == 1'b1 && bus_out == e, {tag, " driven value"}, 32'({bus_oe_lo, bus_out}), 32'({1'b1, e}));
        chk(bus_oe_hi == wide, "R9 upper enable", 32'(bus_oe_hi), 32'(wide));
      end
    end
    rd_en = is68 ? 1'b0 : 1'b1;
    clks(3);
    chk(!bus_oe_lo && !bus_oe_hi, "R10 release after strobe", 32'({bus_oe_hi, bus_oe_lo}), 32'd0);
  endtask

  task automatic t_cs_high;
    int w0, r0, o0;
    go_idle(3'b111);
    cs_n = 1'b1; clks(4);
    w0 = wr_cnt; r0 = req_cnt; o0 = oe_cnt;
    bus_in = 16'h1234;
    wr_rw = 1'b0; clks(4); wr_rw = 1'b1; clks(4);
    rd_en = 1'b0; clks(6); rd_en = 1'b1; clks(4);
    chk(wr_cnt == w0 && req_cnt == r0 && oe_cnt == o0, "R2 deselected quiet",
        32'((wr_cnt - w0) + (req_cnt - r0) + (oe_cnt - o0)), 32'd0);
  endtask

  task automatic t_68_read_no_write;
    int w0;
    go_idle(3'b100);
    w0 = wr_cnt; rd_data = 16'h0F0F;
    rd_en = 1'b1; clks(5); rd_en = 1'b0; clks(6);
    chk(wr_cnt == w0, "R5 enable fall with read level", 32'(wr_cnt - w0), 32'd0);
  endtask

  task automatic t_bad_mode(input logic [2:0] m);
    int w0, r0, o0;
    go_idle(m);
    w0 = wr_cnt; r0 = req_cnt; o0 = oe_cnt;
    wr_rw = 1'b0; clks(4); wr_rw = 1'b1; clks(4);
    rd_en = 1'b0; clks(5); rd_en = 1'b1; clks(5);
    wr_rw = 1'b0; rd_en = 1'b1; clks(5); rd_en = 1'b0; clks(5); wr_rw = 1'b1;
    chk(wr_cnt == w0 && req_cnt == r0 && oe_cnt == o0, "R1 unsupported strap quiet",
        32'((wr_cnt - w0) + (req_cnt - r0) + (oe_cnt - o0)), 32'd0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    clks(3);
    t_reset();
    clks(3);
    t_w80(3'b111, 16'hBEEF, 1'b1, "R4 8080 wide write");
    t_w80(3'b111, 16'h1357, 1'b0, "R4 8080 wide command");
    t_w80(3'b110, 16'hA5C3, 1'b1, "R6 8080 narrow write");
    t_w68(3'b100, 16'h7E81, 1'b0, "R5 6800 wide write");
    t_w68(3'b011, 16'hFF42, 1'b1, "R6 6800 narrow write");
    t_68_read_no_write();
    t_cs_high();
    t_read(3'b111, 16'hCAFE, 1'b1, "R7 8080 wide read");
    t_read(3'b110, 16'hA55A, 1'b0, "R9 8080 narrow read");
    t_read(3'b100, 16'h6D2B, 1'b0, "R8 6800 wide read");
    t_read(3'b011, 16'h91E7, 1'b1, "R8 6800 narrow read");
    t_bad_mode(3'b101);
    t_bad_mode(3'b000);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      summary();
    end
  end
endmodule